// File: doc/BRIEF.md
# DRAM ECC Error Logger

This block records details of DRAM ECC errors that an external checker reports. It receives two single-cycle event strobes, one for a correctable error (CE) and one for an uncorrectable error (UE). Each strobe comes with its own failing address, 8-bit syndrome and channel bit. The block keeps one log: the address at 4 KiB granularity, the syndrome and the channel. Beside the log it holds a status register with write-1-to-clear flags and a command register that enables a system-error pulse for each error type.

Capture follows a priority rule. A UE may replace a correctable log that software has not yet cleared. A CE can never displace an existing log. Software can therefore always read the details of the most severe error since the last clear.

All state is reached through a byte-wide register port. Each byte has its own offset. A write is a single-cycle strobe. A read is combinational from the offset that is presented.

Top module: `ecc_err_log`

## Requirements
- R1: The logged address reads as 32 bits little-endian at offsets 0x00–0x03. Bits 31:12 hold the captured address and bits 11:0 always read zero.
- R2: The captured 8-bit syndrome reads at offset 0x04.
- R3: Offset 0x05 returns the captured channel in bit 0, with bits 7:1 reading zero.
- R4: The status register occupies offsets 0x08 (low byte) and 0x09 (high byte). A CE strobe sets bit 0 and a UE strobe sets bit 7, and every other status bit reads zero.
- R5: A write to offset 0x08 clears bit 0 and/or bit 7 where the written byte holds a 1, and leaves them unchanged where it holds 0. A strobe in the same cycle as a clear leaves its bit set.
- R6: A UE strobe while bit 7 is clear captures the UE address, syndrome and channel, even when a CE is already logged.
- R7: A CE strobe captures its data only when both bit 0 and bit 7 are clear. Otherwise the logged fields stay unchanged and only bit 0 is set.
- R8: A UE strobe while bit 7 is already set leaves the logged fields unchanged.
- R9: When CE and UE strobes arrive in the same cycle with bit 7 clear, the UE data is captured and both bits 0 and 7 become set.
- R10: The command register occupies offsets 0x0A/0x0B. Bit 7 (offset 0x0A bit 7) enables the system error on CE and bit 8 (offset 0x0B bit 0) enables it on UE. Both bits are read/write, and all other command bits read zero and ignore writes.
- R11: `serr_o` is high for exactly the one cycle after a strobe that newly sets an enabled status bit. There is no pulse when the type is disabled or its bit was already set.
- R12: After reset every register reads zero. Unmapped offsets read zero, and writes to the log bytes or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_valid_i | input | 1 | Correctable error strobe |
| ce_addr_i | input | 32 | Address of correctable error |
| ce_syn_i | input | 8 | Syndrome of correctable error |
| ce_chan_i | input | 1 | Channel of correctable error |
| ue_valid_i | input | 1 | Uncorrectable error strobe |
| ue_addr_i | input | 32 | Address of uncorrectable error |
| ue_syn_i | input | 8 | Syndrome of uncorrectable error |
| ue_chan_i | input | 1 | Channel of uncorrectable error |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| serr_o | output | 1 | System error pulse |

## Verification
The capture logic is tried with a lone CE, a CE followed by a UE, a CE and a UE in the same cycle, a repeated UE, and a CE arriving after a UE. Each pattern gives different log contents, so a wrong priority shows up as the wrong address or syndrome being read back. The clear path is tried with 0-data writes, single-bit writes, and a write that coincides with a new strobe. The system-error pulse is tried with each enable alone, with both enables, and with the flag already set, which separates the new-event rule from a simple level check.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_ADDR0 = 8'h00;
  localparam logic [REG_AW-1:0] OFS_ADDR3 = 8'h03;
  localparam logic [REG_AW-1:0] OFS_SYN   = 8'h04;
  localparam logic [REG_AW-1:0] OFS_CHAN  = 8'h05;
  localparam logic [REG_AW-1:0] OFS_STS_L = 8'h08;
  localparam logic [REG_AW-1:0] OFS_STS_H = 8'h09;
  localparam logic [REG_AW-1:0] OFS_CMD_L = 8'h0A;
  localparam logic [REG_AW-1:0] OFS_CMD_H = 8'h0B;

  localparam int unsigned STS_CE_BIT = 0;
  localparam int unsigned STS_UE_BIT = 7;
  localparam int unsigned CMD_CE_BIT = 7;
  localparam int unsigned CMD_UE_BIT = 8;

  typedef struct packed {
    logic ce;
    logic ue;
  } flag_t;
endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAIN_LSB = 12,
  parameter int unsigned SYN_W     = 8,
  localparam int unsigned BLK_W    = ADDR_W - GRAIN_LSB
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_valid_i,
  input  logic [ADDR_W-1:0]    ce_addr_i,
  input  logic [SYN_W-1:0]     ce_syn_i,
  input  logic                 ce_chan_i,
  input  logic                 ue_valid_i,
  input  logic [ADDR_W-1:0]    ue_addr_i,
  input  logic [SYN_W-1:0]     ue_syn_i,
  input  logic                 ue_chan_i,
  input  ecc_log_pkg::flag_t   clr_i,
  output ecc_log_pkg::flag_t   flag_o,
  output ecc_log_pkg::flag_t   new_o,
  output logic [BLK_W-1:0]     blk_o,
  output logic [SYN_W-1:0]     syn_o,
  output logic                 chan_o
);
  ecc_log_pkg::flag_t flag_q;
  logic take_ue, take_ce;

  assign take_ue = ue_valid_i && !flag_q.ue;
  // CE only logs into an empty log, and never against a same-cycle UE
  assign take_ce = ce_valid_i && !flag_q.ce && !flag_q.ue && !take_ue;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      blk_o  <= '0;
      syn_o  <= '0;
      chan_o <= 1'b0;
    end else begin
      flag_q.ce <= (flag_q.ce && !clr_i.ce) || ce_valid_i;
      flag_q.ue <= (flag_q.ue && !clr_i.ue) || ue_valid_i;
      if (take_ue) begin
        blk_o  <= ue_addr_i[ADDR_W-1:GRAIN_LSB];
        syn_o  <= ue_syn_i;
        chan_o <= ue_chan_i;
      end else if (take_ce) begin
        blk_o  <= ce_addr_i[ADDR_W-1:GRAIN_LSB];
        syn_o  <= ce_syn_i;
        chan_o <= ce_chan_i;
      end
    end
  end

  assign flag_o = flag_q;
  assign new_o.ce = ce_valid_i && !flag_q.ce;
  assign new_o.ue = ue_valid_i && !flag_q.ue;
endmodule

// File: rtl/ecc_log_regs.sv
module ecc_log_regs #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAIN_LSB = 12,
  parameter int unsigned SYN_W     = 8,
  localparam int unsigned BLK_W    = ADDR_W - GRAIN_LSB,
  localparam int unsigned NBYTES   = ADDR_W / 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ecc_log_pkg::REG_AW-1:0]  reg_addr_i,
  input  logic                            reg_wr_i,
  input  logic [7:0]                      reg_wdata_i,
  output logic [7:0]                      reg_rdata_o,
  input  ecc_log_pkg::flag_t              flag_i,
  input  logic [BLK_W-1:0]                blk_i,
  input  logic [SYN_W-1:0]                syn_i,
  input  logic                            chan_i,
  output ecc_log_pkg::flag_t              clr_o,
  output ecc_log_pkg::flag_t              en_o
);
  import ecc_log_pkg::*;

  logic [ADDR_W-1:0] addr_full;
  logic [15:0]       sts_word, cmd_word;
  logic [7:0]        addr_byte [NBYTES];
  logic              en_ce_q, en_ue_q;

  assign addr_full = {blk_i, {GRAIN_LSB{1'b0}}};

  for (genvar b = 0; b < NBYTES; b++) begin : g_abyte
    assign addr_byte[b] = addr_full[8*b +: 8];
  end

  always_comb begin
    sts_word = '0;
    sts_word[STS_CE_BIT] = flag_i.ce;
    sts_word[STS_UE_BIT] = flag_i.ue;
    cmd_word = '0;
    cmd_word[CMD_CE_BIT] = en_ce_q;
    cmd_word[CMD_UE_BIT] = en_ue_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i <= OFS_ADDR3 && reg_addr_i < REG_AW'(NBYTES))
      reg_rdata_o = addr_byte[reg_addr_i[$clog2(NBYTES)-1:0]];
    else begin
      case (reg_addr_i)
        OFS_SYN:   reg_rdata_o = 8'(syn_i);
        OFS_CHAN:  reg_rdata_o = {7'd0, chan_i};
        OFS_STS_L: reg_rdata_o = sts_word[7:0];
        OFS_STS_H: reg_rdata_o = sts_word[15:8];
        OFS_CMD_L: reg_rdata_o = cmd_word[7:0];
        OFS_CMD_H: reg_rdata_o = cmd_word[15:8];
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  always_comb begin
    clr_o = '0;
    if (reg_wr_i && reg_addr_i == OFS_STS_L) begin
      clr_o.ce = reg_wdata_i[STS_CE_BIT];
      clr_o.ue = reg_wdata_i[STS_UE_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_ce_q <= 1'b0;
      en_ue_q <= 1'b0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == OFS_CMD_L) en_ce_q <= reg_wdata_i[CMD_CE_BIT];
      if (reg_addr_i == OFS_CMD_H) en_ue_q <= reg_wdata_i[CMD_UE_BIT-8];
    end
  end

  assign en_o.ce = en_ce_q;
  assign en_o.ue = en_ue_q;
endmodule

// File: rtl/ecc_log_serr.sv
module ecc_log_serr (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ecc_log_pkg::flag_t new_i,
  input  ecc_log_pkg::flag_t en_i,
  output logic               serr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_o <= 1'b0;
    else         serr_o <= (new_i.ce && en_i.ce) || (new_i.ue && en_i.ue);
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAIN_LSB = 12,
  parameter int unsigned SYN_W     = 8,
  localparam int unsigned BLK_W    = ADDR_W - GRAIN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_valid_i,
  input  logic [ADDR_W-1:0] ce_addr_i,
  input  logic [SYN_W-1:0]  ce_syn_i,
  input  logic              ce_chan_i,
  input  logic              ue_valid_i,
  input  logic [ADDR_W-1:0] ue_addr_i,
  input  logic [SYN_W-1:0]  ue_syn_i,
  input  logic              ue_chan_i,
  input  logic [7:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              serr_o
);
  ecc_log_pkg::flag_t flag, new_ev, clr, en;
  logic [BLK_W-1:0]   log_blk;
  logic [SYN_W-1:0]   log_syn;
  logic               log_chan;

  ecc_log_capture #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB), .SYN_W(SYN_W)) u_cap (
    .clk_i, .rst_ni,
    .ce_valid_i, .ce_addr_i, .ce_syn_i, .ce_chan_i,
    .ue_valid_i, .ue_addr_i, .ue_syn_i, .ue_chan_i,
    .clr_i(clr), .flag_o(flag), .new_o(new_ev),
    .blk_o(log_blk), .syn_o(log_syn), .chan_o(log_chan)
  );

  ecc_log_regs #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB), .SYN_W(SYN_W)) u_regs (
    .clk_i, .rst_ni,
    .reg_addr_i, .reg_wr_i, .reg_wdata_i, .reg_rdata_o,
    .flag_i(flag), .blk_i(log_blk), .syn_i(log_syn), .chan_i(log_chan),
    .clr_o(clr), .en_o(en)
  );

  ecc_log_serr u_serr (
    .clk_i, .rst_ni, .new_i(new_ev), .en_i(en), .serr_o
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAIN_LSB = 12,
  parameter int unsigned SYN_W     = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      ce_valid_i,
  input logic                      ue_valid_i,
  input logic [ADDR_W-1:0]         ue_addr_i,
  input logic [SYN_W-1:0]          ue_syn_i,
  input logic [7:0]                reg_addr_i,
  input logic [7:0]                reg_rdata_o,
  input logic                      serr_o,
  input logic                      ce_f,
  input logic                      ue_f,
  input logic                      en_ce,
  input logic                      en_ue,
  input logic [ADDR_W-GRAIN_LSB-1:0] log_blk,
  input logic [SYN_W-1:0]          log_syn
);
  a_r1_low_addr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 8'h00) |-> (reg_rdata_o == 8'h00));

  a_r3_chan_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 8'h05) |-> (reg_rdata_o[7:1] == 7'd0));

  a_r4_ue_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_valid_i |=> ue_f);

  a_r6_ue_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ue_valid_i && !ue_f) |=>
      (log_blk == $past(ue_addr_i[ADDR_W-1:GRAIN_LSB]) && log_syn == $past(ue_syn_i)));

  a_r7_ce_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ue_valid_i && (ce_f || ue_f)) |=> ($stable(log_blk) && $stable(log_syn)));

  a_r8_ue_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ue_f |=> $stable(log_blk));

  a_r11_serr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> $past((ce_valid_i && !ce_f && en_ce) || (ue_valid_i && !ue_f && en_ue)));
endmodule

bind ecc_err_log ecc_err_log_chk #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB), .SYN_W(SYN_W)) u_chk (
  .clk_i, .rst_ni, .ce_valid_i, .ue_valid_i, .ue_addr_i, .ue_syn_i,
  .reg_addr_i, .reg_rdata_o, .serr_o,
  .ce_f(flag.ce), .ue_f(flag.ue), .en_ce(en.ce), .en_ue(en.ue),
  .log_blk(log_blk), .log_syn(log_syn)
);

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
  logic clk = 0, rst_ni = 0;
  logic ce_v = 0, ue_v = 0, ce_ch = 0, ue_ch = 0, wr = 0;
  logic [31:0] ce_a = 0, ue_a = 0;
  logic [7:0] ce_s = 0, ue_s = 0, ra = 0, wd = 0, rd;
  logic serr;
  int n_chk = 0, n_fail = 0;
  logic serr_seen;

  always #5 clk = ~clk;

  ecc_err_log uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ce_valid_i(ce_v), .ce_addr_i(ce_a), .ce_syn_i(ce_s), .ce_chan_i(ce_ch),
    .ue_valid_i(ue_v), .ue_addr_i(ue_a), .ue_syn_i(ue_s), .ue_chan_i(ue_ch),
    .reg_addr_i(ra), .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .serr_o(serr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd8(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); ra = a; #1 d = rd;
  endtask

  task automatic rd32(output logic [31:0] d);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rd8(8'(i), b);
      d[8*i +: 8] = b;
    end
  endtask

  task automatic wr8(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ra = a; wd = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic strobe(input logic c, input logic u,
                        input logic [31:0] ca, input logic [7:0] cs, input logic cc,
                        input logic [31:0] ua, input logic [7:0] us, input logic uc);
    @(negedge clk);
    ce_v = c; ce_a = ca; ce_s = cs; ce_ch = cc;
    ue_v = u; ue_a = ua; ue_s = us; ue_ch = uc;
    @(negedge clk);
    ce_v = 0; ue_v = 0;
    serr_seen = serr;
  endtask

  task automatic expect_log(string req, logic [31:0] a, logic [7:0] s, logic ch);
    logic [31:0] got; logic [7:0] b;
    rd32(got); check({req, " addr"}, got, {a[31:12], 12'h000});
    rd8(8'h04, b); check({req, " syn"}, b, s);
    rd8(8'h05, b); check({req, " chan"}, b, {7'd0, ch});
  endtask

  task automatic expect_sts(string req, logic [7:0] lo);
    logic [7:0] b;
    rd8(8'h08, b); check({req, " sts_lo"}, b, lo);
    rd8(8'h09, b); check({req, " sts_hi"}, b, 8'h00);
  endtask

  task automatic clear_all;
    wr8(8'h08, 8'h81);
  endtask

  task automatic t_reset;
    logic [7:0] b;
    for (int i = 0; i < 12; i++) begin
      rd8(8'(i), b); check("R12 reset", b, 8'h00);
    end
  endtask

  task automatic t_ce_capture;
    strobe(1, 0, 32'hDEAD_BEEF, 8'h5A, 1, 0, 0, 0);
    expect_log("R1 R2 R3 ce capture", 32'hDEAD_BEEF, 8'h5A, 1);
    expect_sts("R4 ce flag", 8'h01);
  endtask

  task automatic t_ue_over_ce;
    strobe(0, 1, 0, 0, 0, 32'h1234_5678, 8'hC3, 0);
    expect_log("R6 ue over ce", 32'h1234_5678, 8'hC3, 0);
    expect_sts("R4 both flags", 8'h81);
  endtask

  task automatic t_ce_blocked;
    strobe(1, 0, 32'hAAAA_A000, 8'h11, 1, 0, 0, 0);
    expect_log("R7 ce blocked by ue", 32'h1234_5678, 8'hC3, 0);
    wr8(8'h08, 8'h80);
    expect_sts("R5 clear ue only", 8'h01);
    strobe(1, 0, 32'hBBBB_B000, 8'h22, 1, 0, 0, 0);
    expect_log("R7 ce blocked by ce", 32'h1234_5678, 8'hC3, 0);
    clear_all;
    expect_sts("R5 clear both", 8'h00);
  endtask

  task automatic t_ue_hold;
    strobe(0, 1, 0, 0, 0, 32'h0000_3000, 8'h33, 1);
    strobe(0, 1, 0, 0, 0, 32'hFFFF_F000, 8'h44, 0);
    expect_log("R8 ue hold", 32'h0000_3000, 8'h33, 1);
    expect_sts("R8 flags", 8'h80);
    clear_all;
  endtask

  task automatic t_simul;
    strobe(1, 1, 32'h7000_0000, 8'h77, 0, 32'h8000_1000, 8'h88, 1);
    expect_log("R9 simultaneous", 32'h8000_1000, 8'h88, 1);
    expect_sts("R9 flags", 8'h81);
    clear_all;
  endtask

  task automatic t_w1c;
    strobe(1, 1, 32'h1000, 8'h01, 0, 32'h2000, 8'h02, 0);
    wr8(8'h08, 8'h00);
    expect_sts("R5 zero write", 8'h81);
    wr8(8'h08, 8'h01);
    expect_sts("R5 clear ce only", 8'h80);
    clear_all;
    // clear coinciding with a new CE: set wins
    @(negedge clk); ra = 8'h08; wd = 8'h01; wr = 1; ce_v = 1; ce_a = 32'h5000; ce_s = 8'h55;
    @(negedge clk); wr = 0; ce_v = 0;
    expect_sts("R5 set beats clear", 8'h01);
    clear_all;
  endtask

  task automatic t_cmd;
    logic [7:0] b;
    wr8(8'h0A, 8'hFF); rd8(8'h0A, b); check("R10 cmd lo", b, 8'h80);
    wr8(8'h0B, 8'hFF); rd8(8'h0B, b); check("R10 cmd hi", b, 8'h01);
    wr8(8'h0A, 8'h00); rd8(8'h0A, b); check("R10 cmd lo off", b, 8'h00);
    rd8(8'h0B, b); check("R10 cmd hi kept", b, 8'h01);
  endtask

  task automatic t_serr;
    // UE enabled, CE disabled (after t_cmd)
    strobe(1, 0, 32'h1000, 8'h01, 0, 0, 0, 0);
    check("R11 ce disabled no pulse", serr_seen, 1'b0);
    strobe(0, 1, 0, 0, 0, 32'h2000, 8'h02, 0);
    check("R11 ue pulse", serr_seen, 1'b1);
    @(negedge clk); check("R11 one cycle", serr, 1'b0);
    strobe(0, 1, 0, 0, 0, 32'h3000, 8'h03, 0);
    check("R11 already set no pulse", serr_seen, 1'b0);
    clear_all;
    wr8(8'h0A, 8'h80);
    strobe(1, 0, 32'h4000, 8'h04, 0, 0, 0, 0);
    check("R11 ce pulse", serr_seen, 1'b1);
    clear_all;
  endtask

  task automatic t_ro_writes;
    logic [7:0] b;
    strobe(1, 0, 32'hCAFE_F000, 8'h9C, 1, 0, 0, 0);
    wr8(8'h00, 8'hFF); wr8(8'h03, 8'h00); wr8(8'h04, 8'h00); wr8(8'h05, 8'h00);
    wr8(8'h20, 8'hFF); wr8(8'h09, 8'hFF);
    expect_log("R12 ro writes", 32'hCAFE_F000, 8'h9C, 1);
    expect_sts("R12 sts hi write", 8'h01);
    rd8(8'h20, b); check("R12 unmapped", b, 8'h00);
    clear_all;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset;
    t_ce_capture;
    t_ue_over_ce;
    t_ce_blocked;
    t_ue_hold;
    t_simul;
    t_w1c;
    t_cmd;
    t_serr;
    t_ro_writes;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule